// File: doc/BRIEF.md
# Radix-2 Butterfly Index Sequencer

This block walks the addressing pattern of an in-place radix-2 transform over N points, where N is a power of two chosen at run time. Three nested loops are counted. The outer loop is the butterfly span, which starts at 2 and doubles up to N. The middle loop is the group base, which runs from 0 to N minus the span in steps of one span. The inner loop is the element within the group, which covers half a span. On every advancing cycle the block presents one element. It shows an index together with a 3-bit vector that marks which loop levels end on that element.

A mode input chooses what the index means. It can be the lower operand of the butterfly, the upper operand half a span away, or the position in a twiddle-factor table. The group order and the element order can each be reversed, and a constant base is added to every index. When the last element of the last span has been consumed, the walk starts again from the first element. A pulse on `start` captures the configuration and restarts the walk. `advance` lets the consumer stall the sequence.

Top module: `bfly_sched`

## Requirements
- R1: After reset `valid` is 0, and it stays 0 until `start` is pulsed.
- R2: In mode 2'b00, the index is the lower leg j = base + e. The span takes the values 2, 4, …, N in that order. The group base goes from 0 to N−span in steps of span. The element e goes from 0 to span/2−1, innermost first.
- R3: In mode 2'b01, the index is the upper leg j + span/2.
- R4: In mode 2'b10, the index is the twiddle position e·(N/span).
- R5: Mode 2'b11 is reserved and gives the same index as mode 2'b00.
- R6: `offset` is added to every emitted index, modulo 2^width of `index`.
- R7: When `inv_mid` is 1, groups are visited from the highest base down to 0. When `inv_inner` is 1, e is visited from span/2−1 down to 0, and the twiddle position follows the reversed e.
- R8: `loopends[0]` is 1 on the last inner step in visiting order. `loopends[1]` is 1 when the inner and middle loops are both on their last step. `loopends[2]` is 1 when all three loops are on their last step.
- R9: After the element flagged with `loopends[2]` is consumed, the next element is the first element of the walk again.
- R10: While `valid` is 1 and `advance` is 0, `index` and `loopends` hold their values and the walk does not move.
- R11: A `start` pulse shows the first element in the next cycle, even when it comes in the middle of a walk. `log2n`, `mode`, `inv_mid`, `inv_inner` and `offset` are sampled only on `start`, and later changes to them have no effect.
- R12: A `log2n` of 0 is treated as 1, and a value above LOG2_NMAX is treated as LOG2_NMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture the configuration and restart the walk |
| advance | input | 1 | Consume the current element and step to the next one |
| log2n | input | SW = $clog2(LOG2_NMAX+1) | log2 of the point count N |
| mode | input | 2 | 00 lower leg, 01 upper leg, 10 twiddle, 11 same as 00 |
| inv_mid | input | 1 | Reverse the group order |
| inv_inner | input | 1 | Reverse the element order |
| offset | input | OFF_W | Constant added to every index |
| index | output | IDX_W = max(OFF_W, LOG2_NMAX)+1 | Current index |
| loopends | output | 3 | Loop-end flags for the current element |
| valid | output | 1 | A walk is active and the current element is meaningful |

## Verification
The bench builds the block with its defaults: LOG2_NMAX = 5 and OFF_W = 8. This allows walks of up to 32 points, which means five spans and 80 elements per pass, so every span can be seen with several groups and with long inner runs. The bench also uses `log2n` values of 0 and 7, which reach both clamp limits. Offsets up to 200 keep the index inside nine bits. Each mode and each combination of reversals is run. Some walks cover two full passes so that the wrap can be checked, and some use a pseudo-random stall pattern.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic [1:0] {
    LEG_LOW  = 2'b00,
    LEG_HIGH = 2'b01,
    LEG_TWID = 2'b10,
    LEG_RSVD = 2'b11
  } bfly_leg_e;
endpackage

// File: rtl/bfly_loop_ctr.sv
module bfly_loop_ctr #(
  parameter int CW = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [SW-1:0] lg,
  output logic [SW-1:0] stage,
  output logic [CW-1:0] grp,
  output logic [CW-1:0] elem,
  output logic [CW-1:0] half_m1,
  output logic [CW-1:0] ngrp_m1,
  output logic          last_e,
  output logic          last_g,
  output logic          last_s
);
  // span = 2 << stage; half = 1 << stage; groups = N / span
  assign half_m1 = (CW'(1) << stage) - CW'(1);
  assign ngrp_m1 = (CW'(1) << (lg - SW'(1) - stage)) - CW'(1);
  assign last_e  = (elem == half_m1);
  assign last_g  = (grp == ngrp_m1);
  assign last_s  = (stage == lg - SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      grp   <= '0;
      elem  <= '0;
    end else if (clear) begin
      stage <= '0;
      grp   <= '0;
      elem  <= '0;
    end else if (step) begin
      if (!last_e) begin
        elem <= elem + CW'(1);
      end else begin
        elem <= '0;
        if (!last_g) begin
          grp <= grp + CW'(1);
        end else begin
          grp   <= '0;
          stage <= last_s ? '0 : stage + SW'(1);
        end
      end
    end
  end

  // R2: an inner step leaves the outer counters alone
  a_r2_inner_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && !last_e |=> elem == $past(elem) + CW'(1) && grp == $past(grp) && stage == $past(stage));
  // R9: the last element wraps to the first
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step && !clear && last_e && last_g && last_s |=> stage == '0 && grp == '0 && elem == '0);
  // R11: a restart lands on the first element
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> stage == '0 && grp == '0 && elem == '0);
endmodule

// File: rtl/bfly_addr.sv
module bfly_addr
  import bfly_pkg::*;
#(
  parameter int CW    = 5,
  parameter int SW    = 3,
  parameter int OFF_W = 8,
  parameter int IDX_W = 9
) (
  input  logic [SW-1:0]    lg,
  input  logic [SW-1:0]    stage,
  input  logic [CW-1:0]    grp,
  input  logic [CW-1:0]    elem,
  input  logic [CW-1:0]    half_m1,
  input  logic [CW-1:0]    ngrp_m1,
  input  bfly_leg_e        leg,
  input  logic             inv_mid,
  input  logic             inv_inner,
  input  logic [OFF_W-1:0] base,
  output logic [IDX_W-1:0] index
);
  function automatic logic [CW-1:0] mirror(input logic [CW-1:0] v,
                                           input logic [CW-1:0] top,
                                           input logic          en);
    return en ? top - v : v;
  endfunction

  function automatic logic [CW-1:0] pick_leg(input bfly_leg_e     m,
                                             input logic [CW-1:0] lo,
                                             input logic [CW-1:0] hi,
                                             input logic [CW-1:0] tw);
    case (m)
      LEG_HIGH: return hi;
      LEG_TWID: return tw;
      default:  return lo;
    endcase
  endfunction

  logic [CW-1:0] gsel, esel, grp_base, lo_leg, hi_leg, twid, sel;

  assign gsel     = mirror(grp, ngrp_m1, inv_mid);
  assign esel     = mirror(elem, half_m1, inv_inner);
  assign grp_base = gsel << (stage + SW'(1));
  assign lo_leg   = grp_base + esel;
  assign hi_leg   = lo_leg + half_m1 + CW'(1);
  assign twid     = esel << (lg - SW'(1) - stage);
  assign sel      = pick_leg(leg, lo_leg, hi_leg, twid);
  assign index    = IDX_W'(sel) + IDX_W'(base);
endmodule

// File: rtl/bfly_sched.sv
module bfly_sched
  import bfly_pkg::*;
#(
  parameter int  LOG2_NMAX = 5,
  parameter int  OFF_W     = 8,
  localparam int SW        = $clog2(LOG2_NMAX + 1),
  localparam int IDX_W     = ((OFF_W > LOG2_NMAX) ? OFF_W : LOG2_NMAX) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic [SW-1:0]    log2n,
  input  logic [1:0]       mode,
  input  logic             inv_mid,
  input  logic             inv_inner,
  input  logic [OFF_W-1:0] offset,
  output logic [IDX_W-1:0] index,
  output logic [2:0]       loopends,
  output logic             valid
);
  localparam int CW = LOG2_NMAX;

  function automatic logic [SW-1:0] clamp_lg(input logic [SW-1:0] v);
    if (v == '0) return SW'(1);
    if (v > SW'(LOG2_NMAX)) return SW'(LOG2_NMAX);
    return v;
  endfunction

  logic             run;
  logic [SW-1:0]    lg_q;
  bfly_leg_e        leg_q;
  logic             inv_mid_q, inv_inner_q;
  logic [OFF_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run         <= 1'b0;
      lg_q        <= SW'(1);
      leg_q       <= LEG_LOW;
      inv_mid_q   <= 1'b0;
      inv_inner_q <= 1'b0;
      base_q      <= '0;
    end else if (start) begin
      run         <= 1'b1;
      lg_q        <= clamp_lg(log2n);
      leg_q       <= bfly_leg_e'(mode);
      inv_mid_q   <= inv_mid;
      inv_inner_q <= inv_inner;
      base_q      <= offset;
    end
  end

  // named internal events
  logic          step_ev;
  logic [SW-1:0] stage;
  logic [CW-1:0] grp, elem, half_m1, ngrp_m1;
  logic          last_e, last_g, last_s;

  assign step_ev = run & advance & ~start;

  bfly_loop_ctr #(.CW(CW), .SW(SW)) i_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start),
    .step    (step_ev),
    .lg      (lg_q),
    .stage   (stage),
    .grp     (grp),
    .elem    (elem),
    .half_m1 (half_m1),
    .ngrp_m1 (ngrp_m1),
    .last_e  (last_e),
    .last_g  (last_g),
    .last_s  (last_s)
  );

  bfly_addr #(.CW(CW), .SW(SW), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_addr (
    .lg        (lg_q),
    .stage     (stage),
    .grp       (grp),
    .elem      (elem),
    .half_m1   (half_m1),
    .ngrp_m1   (ngrp_m1),
    .leg       (leg_q),
    .inv_mid   (inv_mid_q),
    .inv_inner (inv_inner_q),
    .base      (base_q),
    .index     (index)
  );

  assign loopends = {last_e & last_g & last_s, last_e & last_g, last_e};
  assign valid    = run;

  // R1: nothing is presented before the first start
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !start |=> !valid);
  // R8: higher loop-end flags imply the lower ones
  a_r8_nested: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (!loopends[2] || loopends[1]) && (!loopends[1] || loopends[0]));
  // R10: a stall freezes the outputs
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !advance && !start |=> valid && $stable(index) && $stable(loopends));
  // R12: the captured size stays within the supported range
  a_r12_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> lg_q >= SW'(1) && lg_q <= SW'(LOG2_NMAX));
endmodule

// File: tb/test_bfly_sched.sv
module test_bfly_sched;
  localparam int LOG2_NMAX = 5;
  localparam int OFF_W     = 8;
  localparam int SW        = $clog2(LOG2_NMAX + 1);
  localparam int IDX_W     = ((OFF_W > LOG2_NMAX) ? OFF_W : LOG2_NMAX) + 1;
  localparam time CLK_P    = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             advance = 1'b0;
  logic [SW-1:0]    log2n = '0;
  logic [1:0]       mode = '0;
  logic             inv_mid = 1'b0;
  logic             inv_inner = 1'b0;
  logic [OFF_W-1:0] offset = '0;
  logic [IDX_W-1:0] index;
  logic [2:0]       loopends;
  logic             valid;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  typedef struct {
    int    idx;
    int    le;
    string tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  bfly_sched #(.LOG2_NMAX(LOG2_NMAX), .OFF_W(OFF_W)) i_bfly_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .log2n(log2n), .mode(mode), .inv_mid(inv_mid), .inv_inner(inv_inner),
    .offset(offset), .index(index), .loopends(loopends), .valid(valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: consume on advance, check hold on stall
  always @(negedge clk) begin
    if (rst_n && valid && q.size() > 0) begin
      if (advance) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " index"}, int'(index), e.idx);
        check("R8 loopends", int'(loopends), e.le);
      end else begin
        check("R10 held index", int'(index), q[0].idx);
        check("R10 held loopends", int'(loopends), q[0].le);
      end
    end
  end

  // expected walk written from the requirements
  task automatic push_walk(input int lg_in, input int md, input bit im, input bit ii,
                           input int off, input int passes, input int limit, input string tg);
    int lg, n, cnt;
    lg  = (lg_in == 0) ? 1 : ((lg_in > LOG2_NMAX) ? LOG2_NMAX : lg_in);
    n   = 1 << lg;
    cnt = 0;
    for (int p = 0; p < passes; p++) begin
      for (int span = 2; span <= n; span = span * 2) begin
        int half, ng, stride;
        half   = span / 2;
        ng     = n / span;
        stride = n / span;
        for (int gi = 0; gi < ng; gi++) begin
          int b;
          b = (im ? (ng - 1 - gi) : gi) * span;
          for (int ei = 0; ei < half; ei++) begin
            exp_t it;
            int e, j, v, le;
            e = ii ? (half - 1 - ei) : ei;
            j = b + e;
            case (md)
              1: v = j + half;
              2: v = e * stride;
              default: v = j;
            endcase
            le = 0;
            if (ei == half - 1) le = 1;
            if (ei == half - 1 && gi == ng - 1) le = 3;
            if (ei == half - 1 && gi == ng - 1 && span == n) le = 7;
            it.idx = (v + off) % (1 << IDX_W);
            it.le  = le;
            it.tag = (p > 0) ? "R9" : tg;
            if (limit == 0 || cnt < limit) q.push_back(it);
            cnt++;
          end
        end
      end
    end
  endtask

  // driver
  task automatic run_case(input int lg_in, input int md, input bit im, input bit ii,
                          input int off, input int passes, input bit stall,
                          input bit scramble, input int limit, input string tg);
    @(posedge clk); #1;
    log2n = SW'(lg_in); mode = 2'(md); inv_mid = im; inv_inner = ii;
    offset = OFF_W'(off); start = 1'b1; advance = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    push_walk(lg_in, md, im, ii, off, passes, limit, tg);
    if (scramble) begin
      // R11: inputs changed after start must not matter
      log2n = SW'(2); mode = 2'(md ^ 1); inv_mid = ~im; inv_inner = ~ii; offset = OFF_W'(off + 17);
    end
    if (stall) begin
      repeat (3) begin @(posedge clk); #1; end
    end
    while (q.size() > 0) begin
      if (stall) begin
        advance = lfsr[0] | lfsr[3];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end else begin
        advance = 1'b1;
      end
      @(posedge clk); #1;
    end
    advance = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", int'(valid), 0);
    // R2 lower leg, sizes 8 and 32
    run_case(3, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
    run_case(5, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
    // R3 upper leg, R4 twiddle
    run_case(4, 1, 0, 0, 0, 1, 0, 0, 0, "R3");
    run_case(5, 2, 0, 0, 0, 1, 0, 0, 0, "R4");
    // R5 reserved mode
    run_case(4, 3, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R6 offset
    run_case(5, 1, 0, 0, 200, 1, 0, 0, 0, "R6");
    // R7 reversals
    run_case(4, 0, 1, 0, 0, 1, 0, 0, 0, "R7");
    run_case(4, 2, 0, 1, 0, 1, 0, 0, 0, "R7");
    run_case(5, 1, 1, 1, 5, 1, 0, 0, 0, "R7");
    // R9 wrap over two passes, R10 with stalls
    run_case(3, 0, 0, 0, 0, 2, 0, 0, 0, "R9");
    run_case(4, 1, 1, 0, 3, 2, 1, 0, 0, "R10");
    // R11 scrambled inputs, then restart mid-walk
    run_case(5, 2, 0, 1, 9, 1, 0, 1, 0, "R11");
    run_case(5, 0, 0, 0, 0, 1, 0, 0, 10, "R11");
    run_case(4, 1, 0, 0, 0, 1, 0, 0, 0, "R11");
    // R12 clamps
    run_case(0, 1, 0, 0, 0, 2, 0, 0, 0, "R12");
    run_case(7, 0, 0, 1, 0, 1, 0, 0, 0, "R12");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule